// File: doc/BRIEF.md
# Host Wake and Power Handshake Register

This block is the general-purpose control word that a host driver uses to bring up and hold awake the device's internal MAC domain. The host sets an access-request bit, the block raises a wake request towards the power manager, and access to internal resources is granted only once the domain reports that its clock is ready and that it is not on its way into sleep. The same word also tells the host which power-save mode is active and whether the domain is entering sleep. It carries a crystal keep-on request and shows the board strap pins. It also follows an external RF-kill switch and raises a one-cycle interrupt on every toggle of that switch.

A software reset drops the access request and the init-done bit at once. The reported clock-ready bit then falls a fixed, parameterised number of cycles later, which models the time the domain takes to wind down its clocks. The block does no clock gating itself; it only sequences the handshake and encodes the fields.

Top module: `hostwake_ctl`

## Requirements
- R1: After reset the read word holds only the strap pins in bits 9:6; every other bit, `wake_req`, `access_grant` and `rfkill_irq` are 0.
- R2: A write with bit 3 set stores the access request, which reads back in bit 3 and drives `wake_req` high from the cycle after the write until the host clears it.
- R3: Only bits 2 (init-done), 3 (access request) and 10 (crystal keep-on) are host-writable; a write of all ones with idle inputs reads back 0x40C plus the strap pins.
- R4: Bit 0 (clock-ready) reads 1 one cycle after init-done and `dom_clk_ready` are both 1, and reads 0 whenever init-done is 0 outside a software-reset drain.
- R5: Bit 4 (going-to-sleep) shows `dom_sleeping` one cycle after it is sampled.
- R6: `access_grant` is registered: in each cycle it equals bit 3 AND bit 0 AND NOT bit 4 as they were read in the previous cycle.
- R7: Bits 26:24 give the power-save mode as {0, `ps_state`} one cycle after sampling: 000 none, 001 MAC power-down, 010 radio power-down, 011 error.
- R8: Bit 27 follows `rfkill_pin` through a two-flop synchroniser, so a pin change shows in bit 27 after the second clock edge.
- R9: `rfkill_irq` is high for exactly the first cycle in which bit 27 shows a new value, for rising and for falling switch changes alike.
- R10: `sw_reset` clears bits 2 and 3 at the next edge, wins over a write in the same cycle, and leaves bit 10 unchanged.
- R11: If clock-ready is 1 when `sw_reset` is sampled, it stays 1 for DROP_LAT-1 more edges and reads 0 after the DROP_LAT-th edge.
- R12: Bits 9:6 follow `strap_pins` with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| sw_reset | input | 1 | Software reset pulse |
| dom_clk_ready | input | 1 | Internal domain reports clock running |
| dom_sleeping | input | 1 | Internal domain reports entry into sleep |
| ps_state | input | 2 | Power-save state from the power manager |
| rfkill_pin | input | 1 | Asynchronous RF-kill switch pin |
| strap_pins | input | 4 | Board strap configuration pins |
| rd_data | output | 32 | Register read value |
| wake_req | output | 1 | Wake request to the power manager |
| access_grant | output | 1 | Internal access permitted |
| rfkill_irq | output | 1 | One-cycle pulse on a switch toggle |

## Verification
The bench builds the block with DROP_LAT set to 3, so the whole software-reset drain fits in a few cycles and each of its edges can be checked one at a time. With that short window, the bench steps through all eight combinations of request, clock-ready and going-to-sleep for the grant. It also covers every strap and power-save code, both switch directions, and a software reset that arrives together with a write.

// File: rtl/hostwake_ctl.sv
module hostwake_ctl #(
  parameter int DROP_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        sw_reset,
  input  logic        dom_clk_ready,
  input  logic        dom_sleeping,
  input  logic [1:0]  ps_state,
  input  logic        rfkill_pin,
  input  logic [3:0]  strap_pins,
  output logic [31:0] rd_data,
  output logic        wake_req,
  output logic        access_grant,
  output logic        rfkill_irq
);
  localparam int CW = (DROP_LAT < 2) ? 1 : $clog2(DROP_LAT + 1);
  localparam int B_RDY = 0, B_INIT = 2, B_ACC = 3, B_SLP = 4, B_XTAL = 10, B_RFK = 27;
  localparam int STRAP_LO = 6, PS_LO = 24;
  localparam logic [31:0] WR_MASK = (32'd1 << B_INIT) | (32'd1 << B_ACC) | (32'd1 << B_XTAL);
  localparam logic [31:0] SW_CLR  = (32'd1 << B_INIT) | (32'd1 << B_ACC);

  logic [31:0]   host_q;
  logic [CW-1:0] drain_q;
  logic          rdy_q, slp_q, grant_q;
  logic [1:0]    ps_q;
  logic [2:0]    rfk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q  <= '0;
      drain_q <= '0;
      rdy_q   <= 1'b0;
      slp_q   <= 1'b0;
      grant_q <= 1'b0;
      ps_q    <= '0;
      rfk_q   <= '0;
    end else begin
      if (sw_reset)   host_q <= host_q & ~SW_CLR;
      else if (wr_en) host_q <= wr_data & WR_MASK;

      if (sw_reset)            drain_q <= CW'(DROP_LAT);
      else if (drain_q != '0)  drain_q <= drain_q - 1'b1;

      if (drain_q == CW'(1))   rdy_q <= 1'b0;
      else if (drain_q == '0)  rdy_q <= host_q[B_INIT] & dom_clk_ready;

      slp_q   <= dom_sleeping;
      ps_q    <= ps_state;
      rfk_q   <= {rfk_q[1:0], rfkill_pin};
      grant_q <= host_q[B_ACC] & rdy_q & ~slp_q;
    end
  end

  always_comb begin
    rd_data                        = host_q & WR_MASK;
    rd_data[B_RDY]                 = rdy_q;
    rd_data[B_SLP]                 = slp_q;
    rd_data[STRAP_LO+3:STRAP_LO]   = strap_pins;
    rd_data[PS_LO+2:PS_LO]         = {1'b0, ps_q};
    rd_data[B_RFK]                 = rfk_q[1];
  end

  assign wake_req     = host_q[B_ACC];
  assign access_grant = grant_q;
  assign rfkill_irq   = rfk_q[1] ^ rfk_q[2];
endmodule

// File: rtl/hostwake_ctl_chk.sv
module hostwake_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        sw_reset,
  input logic [31:0] rd_data,
  input logic        wake_req,
  input logic        access_grant,
  input logic        rfkill_irq
);
  p_req_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[3]) |-> $past(wr_en && wr_data[3] && !sw_reset));

  p_wake_tracks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(wr_en && wr_data[3]));

  p_ready_needs_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> $past(rd_data[2]));

  p_grant_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    access_grant |-> $past(rd_data[3] && rd_data[0] && !rd_data[4]));

  p_irq_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfkill_irq |-> (rd_data[27] != $past(rd_data[27])));

  p_swreset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!rd_data[3] && !rd_data[2]));
endmodule

bind hostwake_ctl hostwake_ctl_chk u_hostwake_ctl_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sw_reset(sw_reset),
  .rd_data(rd_data), .wake_req(wake_req), .access_grant(access_grant),
  .rfkill_irq(rfkill_irq)
);

// File: tb/test_hostwake_ctl.sv
module test_hostwake_ctl;
  localparam int DL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sw_reset = 1'b0;
  logic        dom_clk_ready = 1'b0;
  logic        dom_sleeping = 1'b0;
  logic [1:0]  ps_state = '0;
  logic        rfkill_pin = 1'b0;
  logic [3:0]  strap_pins = 4'hA;
  logic [31:0] rd_data;
  logic        wake_req, access_grant, rfkill_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostwake_ctl #(.DROP_LAT(DL)) i_hostwake_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sw_reset(sw_reset),
    .dom_clk_ready(dom_clk_ready), .dom_sleeping(dom_sleeping), .ps_state(ps_state),
    .rfkill_pin(rfkill_pin), .strap_pins(strap_pins), .rd_data(rd_data),
    .wake_req(wake_req), .access_grant(access_grant), .rfkill_irq(rfkill_irq)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick;
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] strap_word(input logic [3:0] s);
    return {22'd0, s, 6'd0};
  endfunction

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick;
    // R1 reset state
    chk("R1 rd_data", rd_data, strap_word(4'hA));
    chk("R1 wake_req", {31'd0, wake_req}, 32'd0);
    chk("R1 access_grant", {31'd0, access_grant}, 32'd0);
    chk("R1 rfkill_irq", {31'd0, rfkill_irq}, 32'd0);

    // R12 strap pins, combinational
    for (int s = 0; s < 16; s++) begin
      strap_pins = 4'(s);
      #1;
      chk("R12 straps", {28'd0, rd_data[9:6]}, 32'(s));
    end
    strap_pins = 4'h5;
    #1;

    // R3 writable bits only, R2 request and wake
    host_write(32'hFFFF_FFFF);
    chk("R3 write all ones", rd_data, 32'h0000_040C | strap_word(4'h5));
    chk("R2 wake_req set", {31'd0, wake_req}, 32'd1);
    host_write(32'h0);
    chk("R3 write zero", rd_data, strap_word(4'h5));
    chk("R2 wake_req clear", {31'd0, wake_req}, 32'd0);

    // R4 clock-ready needs init-done and domain ready
    for (int i = 0; i < 4; i++) begin
      dom_clk_ready = i[1];
      host_write({29'd0, i[0], 2'd0});
      tick;
      chk("R4 clock-ready", {31'd0, rd_data[0]}, {31'd0, i[0] & i[1]});
      host_write(32'h0);
      tick;
      chk("R4 ready low without init", {31'd0, rd_data[0]}, 32'd0);
    end

    // R6 grant sweep with R5 and R2
    host_write(32'h4);
    for (int v = 0; v < 8; v++) begin
      dom_clk_ready = v[1];
      dom_sleeping  = v[2];
      host_write({28'd0, v[0], 3'b100});
      tick; tick;
      chk("R5 sleep bit", {31'd0, rd_data[4]}, {31'd0, v[2]});
      chk("R2 wake_req", {31'd0, wake_req}, {31'd0, v[0]});
      chk("R6 grant", {31'd0, access_grant}, {31'd0, v[0] & v[1] & ~v[2]});
    end

    // R6 registered latency: sleep rises, grant falls one cycle later
    dom_clk_ready = 1'b1; dom_sleeping = 1'b0;
    host_write(32'hC);
    tick; tick;
    chk("R6 grant on", {31'd0, access_grant}, 32'd1);
    dom_sleeping = 1'b1;
    tick;
    chk("R5 sleep visible", {31'd0, rd_data[4]}, 32'd1);
    chk("R6 grant still held", {31'd0, access_grant}, 32'd1);
    tick;
    chk("R6 grant dropped", {31'd0, access_grant}, 32'd0);
    dom_sleeping = 1'b0;
    tick;

    // R7 power-save field
    for (int p = 0; p < 4; p++) begin
      ps_state = 2'(p);
      tick;
      chk("R7 ps mode", {29'd0, rd_data[26:24]}, 32'(p));
    end
    ps_state = 2'd0;
    tick;

    // R8 and R9 switch sync and toggle pulse, both directions
    for (int d = 0; d < 2; d++) begin
      rfkill_pin = (d == 0);
      tick;
      chk("R8 bit27 after one edge", {31'd0, rd_data[27]}, {31'd0, d != 0});
      chk("R9 no irq yet", {31'd0, rfkill_irq}, 32'd0);
      tick;
      chk("R8 bit27 after two edges", {31'd0, rd_data[27]}, {31'd0, d == 0});
      chk("R9 irq pulse", {31'd0, rfkill_irq}, 32'd1);
      tick;
      chk("R9 irq single cycle", {31'd0, rfkill_irq}, 32'd0);
    end

    // R10 sw reset beats a same-cycle write, keeps crystal bit
    host_write(32'h40C);
    tick;
    sw_reset = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_000C;
    tick;
    sw_reset = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R10 bits cleared", {29'd0, rd_data[10], rd_data[3], rd_data[2]}, 32'h4);
    chk("R10 wake_req", {31'd0, wake_req}, 32'd0);
    repeat (DL + 2) tick;

    // R11 clock-ready drain after sw reset
    host_write(32'h4);
    tick;
    chk("R11 ready before reset", {31'd0, rd_data[0]}, 32'd1);
    sw_reset = 1'b1;
    tick;
    sw_reset = 1'b0;
    chk("R11 ready held at reset edge", {31'd0, rd_data[0]}, 32'd1);
    for (int k = 1; k < DL; k++) begin
      tick;
      chk("R11 ready held in drain", {31'd0, rd_data[0]}, 32'd1);
    end
    tick;
    chk("R11 ready dropped", {31'd0, rd_data[0]}, 32'd0);
    tick;
    chk("R4 ready stays low after drain", {31'd0, rd_data[0]}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule